// File: doc/BRIEF.md
# Flash Command Suspend-Resume Controller

This block is the command state machine on the device side of a parallel NOR-style flash array. It turns single-cycle bus writes into commands. It runs a timed program or erase operation against a counter-based busy model. It keeps an 8-bit status register and tracks which kind of data a read returns. Array storage, buffer data transfer and query tables are outside the block. The busy model only counts the time that such work would take.

A running program or erase can be paused with a suspend command and continued with a resume command. The pause does not take effect immediately. The request is held until the operation's counter reaches an internal checkpoint, and only then does the ready line go high. While an operation is paused, only a screened set of commands is accepted, and that set depends on which operation is paused. While an erase is paused, a program may be run to completion inside it.

Two events abandon an operation, whether it is running or paused: pulling the reset pin low, or losing the programming voltage. Either event raises a one-cycle abort pulse, and the array contents that were being changed must then be treated as undefined.

Top module: `flash_suspend_ctrl`

## Requirements
- R1: After power-on reset, and while `rp_n` is low, the block reads `status` = 0x80, `read_mode` = 0 (array), `ready` = 1 and `abort` = 0. Any write issued while `rp_n` is low is ignored.
- R2: A write of 0x0040 (word program) or 0x00E8 (buffered program) followed by any data write starts a program. `ready` is then low for exactly PROG_CYCLES clock cycles, and `read_mode` becomes 1 (status).
- R3: A write of 0x0020 followed by 0x00D0 starts an erase that keeps `ready` low for exactly ERASE_CYCLES cycles. If the second write is anything other than 0x00D0, status bits 5 and 4 are set and no erase starts.
- R4: A write of 0x00B0 during a running operation takes effect only when the remaining count is a nonzero multiple of 2^CKPT_LOG2. Until that point the count keeps running, and `ready` rises in the cycle the suspension is taken.
- R5: Status layout: bit 7 = ready, bit 6 = erase suspended, bit 5 = erase error, bit 4 = program error, bit 3 = voltage error, bit 2 = program suspended, bits 1:0 = 0. A suspended erase reads 0xC0 and a suspended program reads 0x84 when no error bits are set.
- R6: A write of 0x00D0 resumes a suspended operation from its frozen count, so the total time `ready` is low equals the operation length plus one cycle per suspension. With nothing suspended, 0x00D0 changes nothing.
- R7: Read mode commands are 0x00FF, 0x0070, 0x0090 and 0x0098. They select `read_mode` 0 (array), 1 (status), 2 (device info) and 3 (query). They are accepted in every state, including while an operation is running or suspended. Suspending an operation leaves `read_mode` unchanged.
- R8: During erase suspend, a program command is accepted and runs its full PROG_CYCLES with status reading 0x40. When it finishes, the block returns to erase suspend (0xC0), and the erase can then be resumed.
- R9: While suspended, erase setup (0x0020) and a second suspend (0x00B0) are ignored. During program suspend, both program commands are also ignored. An ignored command leaves `status`, `ready` and the next-write interpretation untouched.
- R10: A write of 0x0050 clears status bits 5, 4 and 3. It is accepted when idle and while suspended.
- R11: Pulling `rp_n` low while an operation is running or suspended produces a one-cycle `abort` pulse and returns the block to the R1 state.
- R12: If `vpp_ok` is low while an operation is running or suspended, the operation is abandoned. `abort` pulses for one cycle, status bit 3 is set, and bit 4 (program) and/or bit 5 (erase) is set for each operation abandoned. `ready` goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rp_n | input | 1 | Reset pin, sampled each cycle, active low; abandons any operation |
| vpp_ok | input | 1 | Programming voltage within range |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_data | input | DATA_W | Bus write data (command code or program data) |
| status | output | 8 | Status register (layout in R5) |
| read_mode | output | 2 | Current read mode (encoding in R7) |
| ready | output | 1 | High when no operation is actively counting |
| abort | output | 1 | One-cycle pulse when an operation is abandoned |

## Verification
The bench builds the block with PROG_CYCLES = 24, ERASE_CYCLES = 64 and CKPT_LOG2 = 3, giving checkpoints every eight cycles. With these values, one run can suspend an erase partway through a checkpoint interval, run a full nested program, and resume, all in well under a thousand cycles. The suspend requests are placed at different offsets from a checkpoint, so the exact latency to the next checkpoint can be predicted and checked for both operation types.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;

    typedef enum logic [3:0] {
        CMD_NONE,
        CMD_RD_ARRAY,
        CMD_RD_STATUS,
        CMD_CLR_STATUS,
        CMD_RD_INFO,
        CMD_QUERY,
        CMD_WORD_PROG,
        CMD_BUF_PROG,
        CMD_ERASE_SETUP,
        CMD_SUSPEND,
        CMD_CONFIRM
    } cmd_e;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_STATUS = 2'd1,
        RM_INFO   = 2'd2,
        RM_QUERY  = 2'd3
    } rmode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PSETUP,
        ST_ESETUP,
        ST_PBUSY,
        ST_EBUSY,
        ST_PSUSP,
        ST_ESUSP
    } state_e;

    // error flag positions inside the err field
    localparam int E_VPP   = 0;
    localparam int E_PROG  = 1;
    localparam int E_ERASE = 2;

    typedef struct packed {
        state_e     st;
        logic       parked;   // erase suspended underneath a nested program
        logic       pend;     // suspend requested, waiting for a checkpoint
        rmode_e     mode;
        logic [2:0] err;
        logic       abort;
    } ctrl_s;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
    import flash_sr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] wr_data,
    output cmd_e              cmd
);

    logic hi_zero;

    assign hi_zero = ((wr_data >> 8) == '0);

    always_comb begin
        cmd = CMD_NONE;
        if (hi_zero) begin
            unique case (wr_data[7:0])
                8'hFF:   cmd = CMD_RD_ARRAY;
                8'h70:   cmd = CMD_RD_STATUS;
                8'h50:   cmd = CMD_CLR_STATUS;
                8'h90:   cmd = CMD_RD_INFO;
                8'h98:   cmd = CMD_QUERY;
                8'h40:   cmd = CMD_WORD_PROG;
                8'hE8:   cmd = CMD_BUF_PROG;
                8'h20:   cmd = CMD_ERASE_SETUP;
                8'hB0:   cmd = CMD_SUSPEND;
                8'hD0:   cmd = CMD_CONFIRM;
                default: cmd = CMD_NONE;
            endcase
        end
    end

endmodule

// File: rtl/flash_cmd_gate.sv
module flash_cmd_gate
    import flash_sr_pkg::*;
(
    input  state_e st,
    input  logic   parked,
    input  cmd_e   cmd,
    output logic   accept
);

    logic is_read;

    assign is_read = (cmd == CMD_RD_ARRAY) || (cmd == CMD_RD_STATUS) ||
                     (cmd == CMD_RD_INFO)  || (cmd == CMD_QUERY);

    always_comb begin
        accept = 1'b0;
        unique case (st)
            ST_IDLE:  accept = (cmd != CMD_NONE);
            ST_PBUSY: accept = is_read || ((cmd == CMD_SUSPEND) && !parked);
            ST_EBUSY: accept = is_read || (cmd == CMD_SUSPEND);
            ST_ESUSP: accept = is_read || (cmd == CMD_CLR_STATUS) ||
                               (cmd == CMD_CONFIRM) || (cmd == CMD_WORD_PROG) ||
                               (cmd == CMD_BUF_PROG);
            ST_PSUSP: accept = is_read || (cmd == CMD_CLR_STATUS) ||
                               (cmd == CMD_CONFIRM);
            default:  accept = 1'b0;
        endcase
    end

endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
    parameter int LEN       = 40,
    parameter int CKPT_LOG2 = 3
) (
    input  logic clk,
    input  logic por_n,
    input  logic load,
    input  logic run,
    input  logic clear,
    output logic at_ckpt,
    output logic last
);

    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)     cnt_d = '0;
        else if (load) cnt_d = CW'(LEN);
        else if (run)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign at_ckpt = (cnt_q != '0) && (cnt_q[CKPT_LOG2-1:0] == '0);
    assign last    = (cnt_q == CW'(1));

    // frozen count holds across a suspension (R6)
    assert_timer_hold_R6: assert property (@(posedge clk) disable iff (!por_n)
        (!load && !run && !clear) |=> $stable(cnt_q));

    // the count never runs past zero
    assert_timer_no_wrap_R2: assert property (@(posedge clk) disable iff (!por_n)
        (run && !load && !clear) |-> (cnt_q != '0));

endmodule

// File: rtl/flash_suspend_ctrl.sv
module flash_suspend_ctrl
    import flash_sr_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int PROG_CYCLES  = 40,
    parameter int ERASE_CYCLES = 200,
    parameter int CKPT_LOG2    = 3
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rp_n,
    input  logic              vpp_ok,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [7:0]        status,
    output logic [1:0]        read_mode,
    output logic              ready,
    output logic              abort
);

    localparam ctrl_s CTRL_RST = '{st: ST_IDLE, parked: 1'b0, pend: 1'b0,
                                   mode: RM_ARRAY, err: 3'b000, abort: 1'b0};

    ctrl_s cq, nx;
    cmd_e  cmd;
    logic  accept;
    logic  op_live;
    logic  p_load, p_run, p_clr, p_ckpt, p_last;
    logic  e_load, e_run, e_clr, e_ckpt, e_last;

    flash_cmd_decode #(.DATA_W(DATA_W)) u_dec (
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    flash_cmd_gate u_gate (
        .st     (cq.st),
        .parked (cq.parked),
        .cmd    (cmd),
        .accept (accept)
    );

    flash_op_timer #(.LEN(PROG_CYCLES), .CKPT_LOG2(CKPT_LOG2)) u_prog_tmr (
        .clk     (clk),
        .por_n   (por_n),
        .load    (p_load),
        .run     (p_run),
        .clear   (p_clr),
        .at_ckpt (p_ckpt),
        .last    (p_last)
    );

    flash_op_timer #(.LEN(ERASE_CYCLES), .CKPT_LOG2(CKPT_LOG2)) u_erase_tmr (
        .clk     (clk),
        .por_n   (por_n),
        .load    (e_load),
        .run     (e_run),
        .clear   (e_clr),
        .at_ckpt (e_ckpt),
        .last    (e_last)
    );

    assign op_live = (cq.st == ST_PBUSY) || (cq.st == ST_EBUSY) ||
                     (cq.st == ST_PSUSP) || (cq.st == ST_ESUSP) || cq.parked;

    always_comb begin
        nx       = cq;
        nx.abort = 1'b0;
        p_load   = 1'b0;
        p_run    = 1'b0;
        p_clr    = 1'b0;
        e_load   = 1'b0;
        e_run    = 1'b0;
        e_clr    = 1'b0;

        if (!rp_n) begin
            nx        = CTRL_RST;
            nx.abort  = op_live;
            p_clr     = 1'b1;
            e_clr     = 1'b1;
        end else if (op_live && !vpp_ok) begin
            nx.abort      = 1'b1;
            nx.err[E_VPP] = 1'b1;
            if ((cq.st == ST_PBUSY) || (cq.st == ST_PSUSP))
                nx.err[E_PROG] = 1'b1;
            if ((cq.st == ST_EBUSY) || (cq.st == ST_ESUSP) || cq.parked)
                nx.err[E_ERASE] = 1'b1;
            nx.st     = ST_IDLE;
            nx.parked = 1'b0;
            nx.pend   = 1'b0;
            p_clr     = 1'b1;
            e_clr     = 1'b1;
        end else begin
            // busy model: suspend at checkpoint, finish, or count down
            unique case (cq.st)
                ST_PBUSY: begin
                    if (cq.pend && p_ckpt) begin
                        nx.st   = ST_PSUSP;
                        nx.pend = 1'b0;
                    end else if (p_last) begin
                        p_clr     = 1'b1;
                        nx.pend   = 1'b0;
                        nx.st     = cq.parked ? ST_ESUSP : ST_IDLE;
                        nx.parked = 1'b0;
                    end else begin
                        p_run = 1'b1;
                    end
                end
                ST_EBUSY: begin
                    if (cq.pend && e_ckpt) begin
                        nx.st   = ST_ESUSP;
                        nx.pend = 1'b0;
                    end else if (e_last) begin
                        e_clr   = 1'b1;
                        nx.pend = 1'b0;
                        nx.st   = ST_IDLE;
                    end else begin
                        e_run = 1'b1;
                    end
                end
                default: ;
            endcase

            // bus writes
            if (wr_en) begin
                unique case (cq.st)
                    ST_PSETUP: begin
                        nx.st   = ST_PBUSY;
                        nx.pend = 1'b0;
                        p_load  = 1'b1;
                    end
                    ST_ESETUP: begin
                        if (cmd == CMD_CONFIRM) begin
                            nx.st   = ST_EBUSY;
                            nx.pend = 1'b0;
                            e_load  = 1'b1;
                        end else begin
                            nx.err[E_PROG]  = 1'b1;
                            nx.err[E_ERASE] = 1'b1;
                            nx.st           = ST_IDLE;
                        end
                    end
                    default: begin
                        if (accept) begin
                            unique case (cmd)
                                CMD_RD_ARRAY:   nx.mode = RM_ARRAY;
                                CMD_RD_STATUS:  nx.mode = RM_STATUS;
                                CMD_RD_INFO:    nx.mode = RM_INFO;
                                CMD_QUERY:      nx.mode = RM_QUERY;
                                CMD_CLR_STATUS: nx.err  = '0;
                                CMD_WORD_PROG, CMD_BUF_PROG: begin
                                    nx.st     = ST_PSETUP;
                                    nx.mode   = RM_STATUS;
                                    nx.parked = (cq.st == ST_ESUSP);
                                end
                                CMD_ERASE_SETUP: begin
                                    nx.st   = ST_ESETUP;
                                    nx.mode = RM_STATUS;
                                end
                                CMD_SUSPEND: begin
                                    if (((cq.st == ST_PBUSY) || (cq.st == ST_EBUSY)) &&
                                        (nx.st == cq.st))
                                        nx.pend = 1'b1;
                                end
                                CMD_CONFIRM: begin
                                    if (cq.st == ST_ESUSP)      nx.st = ST_EBUSY;
                                    else if (cq.st == ST_PSUSP) nx.st = ST_PBUSY;
                                end
                                default: ;
                            endcase
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cq <= CTRL_RST;
        else        cq <= nx;
    end

    assign ready     = !((cq.st == ST_PBUSY) || (cq.st == ST_EBUSY));
    assign status    = {ready,
                        (cq.st == ST_ESUSP) || cq.parked,
                        cq.err[E_ERASE],
                        cq.err[E_PROG],
                        cq.err[E_VPP],
                        (cq.st == ST_PSUSP),
                        2'b00};
    assign read_mode = cq.mode;
    assign abort     = cq.abort;

    // suspension is taken only at a timer checkpoint (R4)
    assert_erase_susp_ckpt_R4: assert property (@(posedge clk) disable iff (!por_n)
        ((cq.st == ST_ESUSP) && ($past(cq.st) == ST_EBUSY)) |-> $past(e_ckpt));

    assert_prog_susp_ckpt_R4: assert property (@(posedge clk) disable iff (!por_n)
        ((cq.st == ST_PSUSP) && ($past(cq.st) == ST_PBUSY)) |-> $past(p_ckpt));

    // suspend bits only appear together with ready (R5)
    assert_prog_susp_bits_R5: assert property (@(posedge clk) disable iff (!por_n)
        status[2] |-> (status[7] && !status[6]));

    assert_erase_susp_bits_R5: assert property (@(posedge clk) disable iff (!por_n)
        $rose(status[6]) |-> status[7]);

    // suspending leaves the read mode alone (R7)
    assert_susp_keeps_mode_R7: assert property (@(posedge clk) disable iff (!por_n)
        (($past(cq.st) == ST_EBUSY) && (cq.st == ST_ESUSP) && !$past(wr_en))
        |-> (read_mode == $past(read_mode)));

    // an abandoned operation leaves nothing running or suspended (R11, R12)
    assert_abort_idle_R11: assert property (@(posedge clk) disable iff (!por_n)
        abort |-> (ready && !status[6] && !status[2]));

    assert_abort_pulse_R12: assert property (@(posedge clk) disable iff (!por_n)
        abort |=> !abort);

endmodule

// File: tb/flash_suspend_ctrl_tb.sv
module flash_suspend_ctrl_tb;

    localparam int DATA_W = 16;
    localparam int PROG   = 24;
    localparam int ERASE  = 64;
    localparam int CKL    = 3;
    localparam int CK     = 1 << CKL;

    logic              clk = 1'b0;
    logic              por_n = 1'b0;
    logic              rp_n = 1'b1;
    logic              vpp_ok = 1'b1;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [7:0]        status;
    logic [1:0]        read_mode;
    logic              ready;
    logic              abort;

    int n_checks = 0;
    int n_errs   = 0;
    int busy_cnt = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    flash_suspend_ctrl #(
        .DATA_W(DATA_W), .PROG_CYCLES(PROG),
        .ERASE_CYCLES(ERASE), .CKPT_LOG2(CKL)
    ) u_dut (
        .clk(clk), .por_n(por_n), .rp_n(rp_n), .vpp_ok(vpp_ok),
        .wr_en(wr_en), .wr_data(wr_data),
        .status(status), .read_mode(read_mode), .ready(ready), .abort(abort)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (!ready) busy_cnt++;
    endtask

    task automatic issue(input logic [DATA_W-1:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        step();
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic wait_ready();
        for (int k = 0; k < 1000 && !ready; k++) step();
    endtask

    // samples with ready low, up to and including the pend edge = s;
    // the remaining count then runs down to the next multiple of CK
    function automatic int exp_susp(input int len, input int s);
        int rem;
        rem = len - s + 1;
        return s + (rem % CK);
    endfunction

    task automatic t_reset();
        chk("R1 status", int'(status), 'h80);
        chk("R1 mode", int'(read_mode), 0);
        chk("R1 ready", int'(ready), 1);
        chk("R1 abort", int'(abort), 0);
    endtask

    task automatic t_read_modes();
        issue('h0090); chk("R7 info", int'(read_mode), 2);
        issue('h0098); chk("R7 query", int'(read_mode), 3);
        issue('h0070); chk("R7 status", int'(read_mode), 1);
        issue('h00FF); chk("R7 array", int'(read_mode), 0);
        issue('h00D0);
        chk("R6 resume noop status", int'(status), 'h80);
        chk("R6 resume noop mode", int'(read_mode), 0);
    endtask

    task automatic t_program();
        issue('h0040); busy_cnt = 0; issue('hABCD); wait_ready();
        chk("R2 word program length", busy_cnt, PROG);
        chk("R2 mode", int'(read_mode), 1);
        chk("R2 status", int'(status), 'h80);
        issue('h00E8); busy_cnt = 0; issue('h0001); wait_ready();
        chk("R2 buffered program length", busy_cnt, PROG);
    endtask

    task automatic t_erase();
        issue('h0020); issue('h0011);
        chk("R3 bad confirm", int'(status), 'hB0);
        chk("R3 bad confirm ready", int'(ready), 1);
        issue('h0050);
        chk("R10 clear idle", int'(status), 'h80);
        issue('h0020); busy_cnt = 0; issue('h00D0); wait_ready();
        chk("R3 erase length", busy_cnt, ERASE);
    endtask

    task automatic t_erase_suspend();
        issue('h0020); busy_cnt = 0; issue('h00D0);
        repeat (5) step();
        issue('h00B0);
        wait_ready();
        chk("R4 erase suspend latency", busy_cnt, exp_susp(ERASE, 7));
        chk("R5 erase suspend status", int'(status), 'hC0);
        chk("R7 mode kept", int'(read_mode), 1);
        issue('h0020); issue('h00B0);
        chk("R9 erase setup/suspend ignored", int'(status), 'hC0);
        chk("R9 ready kept", int'(ready), 1);
        issue('h00D0); wait_ready();
        chk("R6 erase total", busy_cnt, ERASE + 1);
        chk("R6 erase done", int'(status), 'h80);
    endtask

    task automatic t_prog_suspend();
        issue('h0040); busy_cnt = 0; issue('h1234);
        issue('h00B0);
        wait_ready();
        chk("R4 program suspend latency", busy_cnt, exp_susp(PROG, 2));
        chk("R5 program suspend status", int'(status), 'h84);
        issue('h0040); issue('h00E8); issue('h0020); issue('h00B0);
        chk("R9 program cmds ignored", int'(status), 'h84);
        chk("R9 mode unchanged", int'(read_mode), 1);
        issue('h00FF);
        chk("R7 read array in suspend", int'(read_mode), 0);
        issue('h00D0); wait_ready();
        chk("R6 program total", busy_cnt, PROG + 1);
        chk("R6 program done", int'(status), 'h80);
    endtask

    task automatic t_clear_in_suspend();
        issue('h0020); issue('h0000);
        issue('h0040); issue('h5555); issue('h00B0); wait_ready();
        chk("R10 error kept in suspend", int'(status), 'hB4);
        issue('h0050);
        chk("R10 clear in suspend", int'(status), 'h84);
        issue('h00D0); wait_ready();
        chk("R10 finish", int'(status), 'h80);
    endtask

    task automatic t_nested();
        issue('h0020); busy_cnt = 0; issue('h00D0); issue('h00B0); wait_ready();
        chk("R8 erase suspended", int'(status), 'hC0);
        issue('h0040); busy_cnt = 0; issue('h7777);
        chk("R8 nested busy status", int'(status), 'h40);
        wait_ready();
        chk("R8 nested program length", busy_cnt, PROG);
        chk("R8 back to erase suspend", int'(status), 'hC0);
        issue('h00D0); wait_ready();
        chk("R8 erase resumed to end", int'(status), 'h80);
    endtask

    task automatic t_vpp();
        issue('h0040); issue('h0F0F); step(); step(); step();
        vpp_ok = 1'b0; step();
        chk("R12 abort prog", int'(abort), 1);
        chk("R12 prog status", int'(status), 'h98);
        step();
        chk("R12 abort one cycle", int'(abort), 0);
        vpp_ok = 1'b1; issue('h0050);
        issue('h0020); issue('h00D0); issue('h00B0); wait_ready();
        vpp_ok = 1'b0; step();
        chk("R12 abort suspended erase", int'(abort), 1);
        chk("R12 erase status", int'(status), 'hA8);
        vpp_ok = 1'b1; issue('h0050);
        chk("R12 cleared", int'(status), 'h80);
    endtask

    task automatic t_reset_pin();
        issue('h0020); issue('h00D0); issue('h00B0); wait_ready();
        issue('h0090);
        rp_n = 1'b0; step();
        chk("R11 abort", int'(abort), 1);
        chk("R11 status", int'(status), 'h80);
        chk("R11 mode", int'(read_mode), 0);
        step();
        chk("R11 abort one cycle", int'(abort), 0);
        issue('h0070);
        chk("R1 write ignored in reset", int'(read_mode), 0);
        rp_n = 1'b1; step();
        chk("R1 ready after reset pin", int'(ready), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_modes();
        t_program();
        t_erase();
        t_erase_suspend();
        t_prog_suspend();
        t_clear_in_suspend();
        t_nested();
        t_vpp();
        t_reset_pin();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule